// File: doc/BRIEF.md
# Floating-Point Status and Exception Word

This block holds the status word of a floating-point unit. From that word it drives the rounding-mode and flush-to-zero controls that the arithmetic datapath uses. It also collects the exceptions that each completed operation reports.

Every completed operation presents a strobe and a five-bit exception vector. Any exception it raises is ORed into a sticky flag field. The flag field sits at a fixed distance above a matching field of enable bits. In the same cycle, an enabled raised exception produces a one-cycle trap request to the pipeline. Software can replace the whole word at once. That write is the only way to clear flags or to change the controls.

Top module: `fp_status_word`

## Requirements
- R1: After reset the word reads all zero, the rounding select is round-to-nearest-even (`rnd_sel` = 4'b0001), `flush_en` is low and `trap_req` is low.
- R2: Word bits [10:9] select the rounding mode, and `rnd_sel` is one-hot with bit k set for mode k: 0 nearest-even, 1 toward zero, 2 toward +infinity, 3 toward -infinity.
- R3: `flush_en` equals word bit 5, which asks the datapath to flush both denormal inputs and denormal results to zero.
- R4: In `op_exc`, bit 0 is inexact, bit 1 is underflow, bit 2 is overflow, bit 3 is divide-by-zero and bit 4 is invalid. The enable bits occupy word bits [4:0] in the same order, and the flag bits occupy word bits [15:11] in the same order.
- R5: When `op_valid` is high, `op_exc` is ORed into the flag bits on the next clock edge. Flags stay set until a software write.
- R6: When no operation raises an exception (either `op_valid` is low or `op_exc` is zero) and no software write occurs, the word does not change.
- R7: `trap_req` is combinational and equals `op_valid` AND the OR of (`op_exc` AND the current enable bits). It is therefore a one-cycle pulse per operation, and the flag update still happens in that cycle.
- R8: When `sw_we` is high, the word takes `sw_wdata` on the next edge, and `rnd_sel` and `flush_en` follow the new contents.
- R9: When a software write and an operation coincide, the software write wins and that operation's exceptions are not merged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | 32 | New status word |
| op_valid | input | 1 | An operation completes this cycle |
| op_exc | input | 5 | Exceptions raised by that operation |
| status | output | 32 | Current status word |
| rnd_sel | output | 4 | One-hot rounding mode for the datapath |
| flush_en | output | 1 | Flush denormals to zero |
| trap_req | output | 1 | Enabled exception raised this cycle |

## Verification
The assertions assume that `op_exc` carries meaning only while `op_valid` is high, and that a software write is a single-cycle strobe whose data is sampled on the same edge. The stimulus drives every input on the falling edge and holds it for a full cycle, so these assumptions always hold. The stimulus mixes directed sequences with pseudo-random cycles that cover writes, operations, collisions between the two, and idle cycles with `op_exc` nonzero but `op_valid` low.

// File: rtl/fp_status_word.sv
module fp_status_word #(
  parameter int W        = 32,
  parameter int NEXC     = 5,
  parameter int ENA_LSB  = 0,
  parameter int FLAG_LSB = 11,
  parameter int RM_LSB   = 9,
  parameter int D_BIT    = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sw_we,
  input  logic [W-1:0]    sw_wdata,
  input  logic            op_valid,
  input  logic [NEXC-1:0] op_exc,
  output logic [W-1:0]    status,
  output logic [3:0]      rnd_sel,
  output logic            flush_en,
  output logic            trap_req
);
  localparam int FLAG_DIST = FLAG_LSB - ENA_LSB;

  logic [W-1:0]    word_q;
  logic [NEXC-1:0] enables;
  logic [W-1:0]    exc_wide;
  logic            raise;

  assign enables  = word_q[ENA_LSB +: NEXC];
  assign raise    = op_valid && (op_exc != '0);
  assign exc_wide = W'(op_exc) << (ENA_LSB + FLAG_DIST);
  assign trap_req = op_valid && ((op_exc & enables) != '0);
  assign flush_en = word_q[D_BIT];
  assign status   = word_q;

  always_comb begin
    rnd_sel = '0;
    rnd_sel[word_q[RM_LSB +: 2]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word_q <= '0;
    else if (sw_we) word_q <= sw_wdata;
    else if (raise) word_q <= word_q | exc_wide;
  end
endmodule

module fp_status_word_chk #(
  parameter int W        = 32,
  parameter int NEXC     = 5,
  parameter int FLAG_LSB = 11
) (
  input logic            clk,
  input logic            rst_n,
  input logic            sw_we,
  input logic [W-1:0]    sw_wdata,
  input logic            op_valid,
  input logic [NEXC-1:0] op_exc,
  input logic [W-1:0]    status,
  input logic [3:0]      rnd_sel,
  input logic            trap_req
);
  p_rnd_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rnd_sel) && rnd_sel != '0);

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_we |=> ((status[FLAG_LSB +: NEXC] & $past(status[FLAG_LSB +: NEXC]))
                == $past(status[FLAG_LSB +: NEXC])));

  p_quiet_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_we && !(op_valid && op_exc != '0)) |=> $stable(status));

  p_trap_needs_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> op_valid && op_exc != '0);

  p_sw_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_we |=> status == $past(sw_wdata));
endmodule

bind fp_status_word fp_status_word_chk #(.W(W), .NEXC(NEXC), .FLAG_LSB(FLAG_LSB)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_wdata(sw_wdata),
  .op_valid(op_valid), .op_exc(op_exc), .status(status),
  .rnd_sel(rnd_sel), .trap_req(trap_req)
);

// File: tb/fp_status_word_tb.sv
module fp_status_word_tb_top;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        sw_we = 0;
  logic [31:0] sw_wdata = '0;
  logic        op_valid = 0;
  logic [4:0]  op_exc = '0;
  logic [31:0] status;
  logic [3:0]  rnd_sel;
  logic        flush_en;
  logic        trap_req;

  int checks = 0;
  int errors = 0;
  logic [31:0] model = '0;

  always #2 clk = ~clk;

  fp_status_word dut_i (
    .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_wdata(sw_wdata),
    .op_valid(op_valid), .op_exc(op_exc), .status(status),
    .rnd_sel(rnd_sel), .flush_en(flush_en), .trap_req(trap_req)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_rnd(logic [31:0] w);
    case (w[10:9])
      2'd0: return 4'b0001;
      2'd1: return 4'b0010;
      2'd2: return 4'b0100;
      default: return 4'b1000;
    endcase
  endfunction

  task automatic step(logic we, logic [31:0] wd, logic v, logic [4:0] e, string tag);
    logic exp_trap;
    @(negedge clk);
    sw_we = we; sw_wdata = wd; op_valid = v; op_exc = e;
    #1;
    exp_trap = v && ((e & model[4:0]) != 0);
    chk("R7 trap", {31'b0, trap_req}, {31'b0, exp_trap});
    @(posedge clk);
    if (we) model = wd;
    else if (v) model = model | ({27'b0, e} << 11);
    #1;
    chk(tag, status, model);
    chk("R2 rnd", {28'b0, rnd_sel}, {28'b0, exp_rnd(model)});
    chk("R3 flush", {31'b0, flush_en}, {31'b0, model[5]});
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 status", status, 32'h0);
    chk("R1 rnd", {28'b0, rnd_sel}, 32'h1);
    chk("R1 flush", {31'b0, flush_en}, 32'h0);
    chk("R1 trap", {31'b0, trap_req}, 32'h0);
    @(negedge clk) rst_n = 1;

    for (int m = 0; m < 4; m++)
      step(1, 32'(m) << 9 | 32'h20, 0, 0, "R8 write mode");
    step(1, 32'h0, 0, 0, "R8 clear");
    step(0, 0, 1, 5'b00100, "R4 overflow lands at bit 13");
    step(0, 0, 1, 5'b10000, "R4 invalid lands at bit 15");
    step(0, 0, 1, 5'b00001, "R5 sticky merge");
    step(0, 0, 0, 5'b11111, "R6 op_valid low ignored");
    step(0, 0, 1, 5'b00000, "R6 no exception");
    step(1, 32'h0000_0008, 0, 0, "R8 enable divzero");
    step(0, 0, 1, 5'b01000, "R7 enabled divzero traps");
    step(0, 0, 1, 5'b00010, "R7 disabled underflow no trap");
    step(1, 32'h0000_0400, 1, 5'b11111, "R9 write beats op");
    for (int i = 0; i < 400; i++)
      step(($urandom % 5) == 0, $urandom, $urandom % 2, 5'($urandom), "R5 random");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule